// File: doc/BRIEF.md
# Self-Clearing Soft Reset Sequencer

This block sits beside the register file of a network interface controller and turns two software reset requests into timed reset pulses. Software writes a one into a trigger bit; the block starts a cycle-exact countdown, drives the matching reset output for the whole countdown, and clears the trigger bit by itself when the count runs out. Software learns that the reset has finished by polling that bit, or by polling a ready flag.

The device-wide soft reset pulses the core reset output for `DEV_CYCLES` clock cycles. The ready flag is low during that pulse and rises on the edge where the pulse ends. A soft reset clears the configuration fields, except for those chosen by `PRESERVE_MASK`, which keep their values. The PHY soft reset holds the PHY reset output for the longer `PHY_CYCLES` count. It can be requested through either of two register bits, and both bits show the same state.

Register map: address 0 is the configuration register, address 1 is the power control register, and address 2 is the PHY control register. Any other address reads as zero and ignores writes.

Top module: `softrst_seq`

## Requirements
- R1: After the synchronous reset, `core_rst_o` and `phy_rst_o` are 0 and `ready_o` is 1. Address 0 reads 0, address 1 reads 0x0000_0001 (ready in bit 0), and address 2 reads 0.
- R2: A write of 1 to address 0 bit 0 starts a device soft reset. Counting from the cycle after the write edge, `core_rst_o` is 1 and address 0 bit 0 reads 1 for exactly `DEV_CYCLES` cycles. Both then read 0.
- R3: `ready_o`, which also appears as address 1 bit 0, is 0 for every cycle in which `core_rst_o` is 1. It returns to 1 on the same edge that clears `core_rst_o`.
- R4: On a write that starts a device soft reset, the configuration bits set in `PRESERVE_MASK` (default bits 15:8) keep their values. All other configuration bits 31:1 become 0, and the rest of the data in that write is discarded.
- R5: A write to address 0 with bit 0 equal to 0 loads data bits 31:1 into the configuration fields. It neither starts nor alters a device soft reset.
- R6: A write of 1 to address 0 bit 0 while a device soft reset is running restarts the count, so `core_rst_o` stays 1 for `DEV_CYCLES` cycles after the newer write.
- R7: A write of 1 to address 1 bit 10 starts a PHY soft reset. Counting from the cycle after the write edge, `phy_rst_o` is 1 for exactly `PHY_CYCLES` cycles, and during that time address 1 bit 10 reads 1. Both then read 0.
- R8: A write of 1 to address 2 bit 15 starts the same PHY soft reset. Address 2 bit 15 and address 1 bit 10 both show whether the PHY reset is running.
- R9: Writing 0 to address 1 bit 10 or to address 2 bit 15 has no effect on the PHY reset. Writing 1 while it runs restarts the `PHY_CYCLES` count.
- R10: The device and PHY soft resets run independently. Neither one starts, stops or stretches the other, and both can end on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Combinational read data |
| core_rst_o | output | 1 | Device soft reset pulse |
| phy_rst_o | output | 1 | PHY soft reset pulse |
| ready_o | output | 1 | Device ready flag |

## Verification
The end of a device soft reset and the end of a PHY soft reset can fall on the same clock edge. At that edge, the ready flag rises while the PHY reset output falls. The bench provokes this by starting the PHY reset first and then starting the device reset exactly `PHY_CYCLES - DEV_CYCLES` cycles later. It judges the result by requiring both outputs to be high in the last shared cycle, and by requiring both reset outputs low with ready high in the very next cycle, with the preserved configuration bits unchanged.

// File: rtl/srst_pkg.sv
package srst_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADDR_CFG    = 4'd0;
    localparam logic [ADDR_W-1:0] ADDR_PWR    = 4'd1;
    localparam logic [ADDR_W-1:0] ADDR_PHYCTL = 4'd2;

    localparam int CFG_TRIG_BIT   = 0;
    localparam int PWR_READY_BIT  = 0;
    localparam int PWR_PHY_BIT    = 10;
    localparam int PHYCTL_RST_BIT = 15;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_PWR,
        SEL_PHYCTL
    } reg_sel_e;

    typedef struct packed {
        logic             en;
        reg_sel_e         sel;
        logic [REG_W-1:0] data;
    } wr_req_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            ADDR_CFG:    return SEL_CFG;
            ADDR_PWR:    return SEL_PWR;
            ADDR_PHYCTL: return SEL_PHYCTL;
            default:     return SEL_NONE;
        endcase
    endfunction

    // A PHY reset request can come from either of two registers.
    function automatic logic phy_request(input wr_req_t w);
        return w.en && (((w.sel == SEL_PWR) && w.data[PWR_PHY_BIT]) ||
                        ((w.sel == SEL_PHYCTL) && w.data[PHYCTL_RST_BIT]));
    endfunction

endpackage

// File: rtl/srst_timer.sv
module srst_timer #(
    parameter int CYCLES = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int              CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= LOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    // Completion: the final counted cycle with no restart arriving.
    assign done = (cnt == LAST) && !start;

    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        start |=> busy); // R2

    AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (busy && !start && cnt == LAST) |=> !busy); // R2

    AST_HOLD_UNTIL_LAST: assert property (@(posedge clk) disable iff (rst)
        (busy && !start && cnt != LAST) |=> busy); // R6

endmodule

// File: rtl/srst_cfg.sv
module srst_cfg
    import srst_pkg::*;
#(
    parameter logic [REG_W-1:0] PRESERVE_MASK = 32'h0000_FF00
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic             trig,
    output logic [REG_W-1:1] fields
);
    localparam logic [REG_W-1:1] KEEP = PRESERVE_MASK[REG_W-1:1];

    assign trig = wr_en && wdata[CFG_TRIG_BIT];

    always_ff @(posedge clk) begin
        if (rst)
            fields <= '0;
        else if (trig)
            fields <= fields & KEEP;
        else if (wr_en)
            fields <= wdata[REG_W-1:1];
    end

    AST_KEEP_PRESERVED: assert property (@(posedge clk) disable iff (rst)
        trig |=> ((fields & KEEP) == $past(fields & KEEP))); // R4

    AST_CLEAR_VOLATILE: assert property (@(posedge clk) disable iff (rst)
        trig |=> ((fields & ~KEEP) == '0)); // R4

    AST_FIELD_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wdata[CFG_TRIG_BIT]) |=> (fields == $past(wdata[REG_W-1:1]))); // R5

endmodule

// File: rtl/softrst_seq.sv
module softrst_seq
    import srst_pkg::*;
#(
    parameter int               DEV_CYCLES    = 100,
    parameter int               PHY_CYCLES    = 5000,
    parameter logic [REG_W-1:0] PRESERVE_MASK = 32'h0000_FF00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              core_rst_o,
    output logic              phy_rst_o,
    output logic              ready_o
);
    wr_req_t          req;
    logic             dev_start, dev_busy, dev_done;
    logic             phy_start, phy_busy, phy_done;
    logic [REG_W-1:1] cfg_fields;
    logic             ready_q;

    assign req.en   = wr_en;
    assign req.sel  = decode_addr(wr_addr);
    assign req.data = wr_data;

    srst_cfg #(
        .PRESERVE_MASK (PRESERVE_MASK)
    ) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (req.en && (req.sel == SEL_CFG)),
        .wdata  (req.data),
        .trig   (dev_start),
        .fields (cfg_fields)
    );

    assign phy_start = phy_request(req);

    srst_timer #(.CYCLES(DEV_CYCLES)) u_dev_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (dev_start),
        .busy  (dev_busy),
        .done  (dev_done)
    );

    srst_timer #(.CYCLES(PHY_CYCLES)) u_phy_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (phy_start),
        .busy  (phy_busy),
        .done  (phy_done)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ready_q <= 1'b1;
        else if (dev_start)
            ready_q <= 1'b0;
        else if (dev_done)
            ready_q <= 1'b1;
    end

    assign core_rst_o = dev_busy;
    assign phy_rst_o  = phy_busy;
    assign ready_o    = ready_q;

    always_comb begin
        rd_data = '0;
        case (decode_addr(rd_addr))
            SEL_CFG: rd_data = {cfg_fields, dev_busy};
            SEL_PWR: begin
                rd_data[PWR_READY_BIT] = ready_q;
                rd_data[PWR_PHY_BIT]   = phy_busy;
            end
            SEL_PHYCTL: rd_data[PHYCTL_RST_BIT] = phy_busy;
            default: rd_data = '0;
        endcase
    end

    AST_READY_LOW_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        core_rst_o |-> !ready_o); // R3

    AST_READY_ON_FINISH: assert property (@(posedge clk) disable iff (rst)
        $fell(core_rst_o) |-> ready_o); // R3

    AST_ZERO_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && req.sel == SEL_CFG && !wr_data[CFG_TRIG_BIT] && !core_rst_o)
        |=> !core_rst_o); // R5

    AST_PHY_ZERO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!phy_start && !phy_rst_o) |=> !phy_rst_o); // R9

    AST_PHY_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        phy_done |=> !phy_rst_o); // R7

    AST_DEV_LEAVES_PHY: assert property (@(posedge clk) disable iff (rst)
        (dev_start && !phy_start && !phy_rst_o) |=> !phy_rst_o); // R10

endmodule

// File: tb/softrst_seq_bench.sv
module softrst_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NDEV       = 8;
    localparam int NPHY       = 20;

    localparam int K_READ = 0;
    localparam int K_CORE = 1;
    localparam int K_PHY  = 2;
    localparam int K_RDY  = 3;

    typedef struct {
        int          cyc;
        int          kind;
        logic [3:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        core_rst_o, phy_rst_o, ready_o;

    item_t sb[$];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    finished = 0;

    softrst_seq #(
        .DEV_CYCLES    (NDEV),
        .PHY_CYCLES    (NPHY),
        .PRESERVE_MASK (32'h0000_FF00)
    ) u_softrst_seq (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .core_rst_o (core_rst_o),
        .phy_rst_o  (phy_rst_o),
        .ready_o    (ready_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(input int c, input int kind, input logic [3:0] a,
                             input logic [31:0] e, input string tag);
        item_t it;
        it.cyc = c; it.kind = kind; it.addr = a; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic judge(input string tag, input logic [31:0] act, input logic [31:0] e);
        checks++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s cycle %0d: actual 0x%08h expected 0x%08h", tag, cyc, act, e);
        end
    endtask

    // Monitor: at each falling edge, compare every item due in this cycle.
    initial begin
        forever begin
            @(negedge clk);
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].cyc == cyc) begin
                    case (sb[i].kind)
                        K_READ: begin
                            rd_addr = sb[i].addr;
                            #1;
                            judge(sb[i].tag, rd_data, sb[i].exp);
                        end
                        K_CORE: judge(sb[i].tag, {31'd0, core_rst_o}, sb[i].exp);
                        K_PHY:  judge(sb[i].tag, {31'd0, phy_rst_o}, sb[i].exp);
                        default: judge(sb[i].tag, {31'd0, ready_o}, sb[i].exp);
                    endcase
                    sb.delete(i);
                end else if (sb[i].cyc < cyc) begin
                    judge({sb[i].tag, " missed"}, 32'hDEAD_DEAD, sb[i].exp);
                    sb.delete(i);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int c0, c1;
        idle(3);
        rst = 1'b0;

        // R1 reset state
        c0 = cyc;
        expect_at(c0 + 1, K_CORE, 0, 0, "R1 core");
        expect_at(c0 + 1, K_PHY, 0, 0, "R1 phy");
        expect_at(c0 + 1, K_RDY, 0, 1, "R1 ready");
        expect_at(c0 + 1, K_READ, 0, 32'h0, "R1 cfg");
        expect_at(c0 + 1, K_READ, 1, 32'h1, "R1 pwr");
        expect_at(c0 + 1, K_READ, 2, 32'h0, "R1 phyctl");
        idle(2);

        // R5 plain field write
        c0 = cyc;
        expect_at(c0 + 1, K_READ, 0, 32'hFFFF_AB06, "R5 fields");
        expect_at(c0 + 1, K_CORE, 0, 0, "R5 no start");
        expect_at(c0 + 2, K_RDY, 0, 1, "R5 ready kept");
        wr(0, 32'hFFFF_AB06);
        idle(2);

        // R2 R3 R4 device soft reset
        c0 = cyc;
        expect_at(c0 + 1, K_READ, 0, 32'h0000_AB01, "R4 preserved during");
        expect_at(c0 + 1, K_CORE, 0, 1, "R2 core up");
        expect_at(c0 + 1, K_RDY, 0, 0, "R3 ready low");
        expect_at(c0 + 1, K_READ, 1, 32'h0, "R3 pwr ready bit low");
        expect_at(c0 + NDEV, K_CORE, 0, 1, "R2 core last");
        expect_at(c0 + NDEV, K_RDY, 0, 0, "R3 ready low last");
        expect_at(c0 + NDEV + 1, K_CORE, 0, 0, "R2 self clear");
        expect_at(c0 + NDEV + 1, K_RDY, 0, 1, "R3 ready up");
        expect_at(c0 + NDEV + 1, K_READ, 0, 32'h0000_AB00, "R4 preserved after");
        expect_at(c0 + NDEV + 1, K_READ, 1, 32'h1, "R3 pwr ready bit");
        wr(0, 32'h1234_5671);
        idle(NDEV + 3);

        // R6 restart while running
        c0 = cyc;
        c1 = c0 + 3;
        expect_at(c0 + NDEV + 1, K_CORE, 0, 1, "R6 stretched");
        expect_at(c1 + NDEV, K_CORE, 0, 1, "R6 last");
        expect_at(c1 + NDEV + 1, K_CORE, 0, 0, "R6 clear");
        expect_at(c1 + NDEV + 1, K_RDY, 0, 1, "R6 ready");
        wr(0, 32'h1);
        idle(2);
        wr(0, 32'h1);
        idle(NDEV + 3);

        // R7 PHY reset via power register, R9 zero write ignored
        c0 = cyc;
        expect_at(c0 + 1, K_PHY, 0, 1, "R7 phy up");
        expect_at(c0 + 1, K_READ, 1, 32'h0000_0401, "R7 pwr bit");
        expect_at(c0 + 1, K_READ, 2, 32'h0000_8000, "R8 mirror");
        expect_at(c0 + 1, K_CORE, 0, 0, "R10 core idle");
        expect_at(c0 + NPHY, K_PHY, 0, 1, "R9 zero write no effect");
        expect_at(c0 + NPHY + 1, K_PHY, 0, 0, "R7 self clear");
        expect_at(c0 + NPHY + 1, K_READ, 1, 32'h1, "R7 pwr bit clear");
        wr(1, 32'h0000_0400);
        wr(1, 32'h0);
        wr(2, 32'h0);
        idle(NPHY + 3);

        // R8 PHY reset via PHY control register
        c0 = cyc;
        expect_at(c0 + 1, K_READ, 2, 32'h0000_8000, "R8 phyctl bit");
        expect_at(c0 + 1, K_READ, 1, 32'h0000_0401, "R8 pwr mirror");
        expect_at(c0 + NPHY, K_PHY, 0, 1, "R8 last");
        expect_at(c0 + NPHY + 1, K_PHY, 0, 0, "R8 clear");
        expect_at(c0 + NPHY + 1, K_READ, 2, 32'h0, "R8 phyctl clear");
        wr(2, 32'h0000_8000);
        idle(NPHY + 3);

        // R9 restart through the other register
        c0 = cyc;
        c1 = c0 + 4;
        expect_at(c0 + NPHY + 1, K_PHY, 0, 1, "R9 restarted");
        expect_at(c1 + NPHY + 1, K_PHY, 0, 0, "R9 clear");
        wr(2, 32'h0000_8000);
        idle(3);
        wr(1, 32'h0000_0400);
        idle(NPHY + 3);

        // R10 both resets end on the same edge
        c0 = cyc;
        expect_at(c0 + NPHY, K_PHY, 0, 1, "R10 phy last");
        expect_at(c0 + NPHY, K_CORE, 0, 1, "R10 core last");
        expect_at(c0 + NPHY + 1, K_PHY, 0, 0, "R10 phy clear");
        expect_at(c0 + NPHY + 1, K_CORE, 0, 0, "R10 core clear");
        expect_at(c0 + NPHY + 1, K_RDY, 0, 1, "R10 ready");
        expect_at(c0 + NPHY + 1, K_READ, 0, 32'h0000_AB00, "R10 R4 fields kept");
        wr(1, 32'h0000_0400);
        idle(NPHY - NDEV - 1);
        wr(0, 32'h1);
        idle(NDEV + 4);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule